// File: doc/BRIEF.md
# Coincident-Selection Bit-Sliced RAM

This block is a small synchronous random-access memory. By default it holds sixteen one-bit words. The storage cells sit in a two-dimensional matrix of rows and columns. One decoder turns the upper address bits into a one-hot row select. A second decoder turns the lower address bits into a one-hot column select. A cell takes part in an access only where an active row crosses an active column. This split needs far fewer decode gates than a single full-width address decoder.

A host controls each access with a chip-select line and a read/write-bar line. A write happens on the rising clock edge when chip select is high and read/write-bar is low. A read is registered. The stored word appears on the data output one clock after the address is presented, together with a high output-valid flag. While the chip is not being read, the output is modelled as disconnected: the valid flag is low and the data lines are forced to zero.

The row, column and data widths are parameters. An 8 x 2 arrangement is built with two row bits, one column bit and a two-bit data word.

Top module: `coincident_ram`

## Requirements
- R1: With default parameters the memory stores 16 independent one-bit words, selected by a 4-bit address. A value written at one address is read back from that address only.
- R2: The upper ROW_BITS address bits drive a row decoder and the lower COL_BITS bits drive a column decoder. Outside reset, each decoder has exactly one active output.
- R3: A cell whose row and column are not both selected keeps its stored value. No cell changes in a cycle without a write.
- R4: When chipSel is 1 and readWriteN is 0 at a rising edge, dataIn is stored at the word selected by addr.
- R5: When chipSel is 1 and readWriteN is 1 at a rising edge, the word stored at addr as of that edge appears on dataOut after that edge, and dataValid is 1.
- R6: After any edge at which a read is not taking place, dataValid is 0 and dataOut is all zeros. An edge with chipSel at 0 stores nothing, whatever readWriteN is.
- R7: At a rising edge with rst at 1, every cell is cleared to zero and dataValid goes to 0, regardless of the other inputs.
- R8: A read in the cycle after a write to the same address returns the newly written value.
- R9: With ROW_BITS=2, COL_BITS=1 and DATA_W=2, the block behaves as an 8-word by 2-bit memory. Its address is 3 bits wide and it follows R3 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ROW_BITS+COL_BITS | Word address: row bits in the upper part, column bits in the lower part |
| dataIn | input | DATA_W | Write data |
| chipSel | input | 1 | Chip select, active high |
| readWriteN | input | 1 | 1 selects read, 0 selects write |
| dataOut | output | DATA_W | Registered read data, zero when not valid |
| dataValid | output | 1 | 1 when dataOut carries read data; low models the disconnected output |

## Verification
The assertions check several rules on every cycle:
- both decoders stay one-hot;
- the write and read strobes never coincide;
- the cell matrix is unchanged in any cycle without a write;
- the valid flag follows the read condition of the previous edge;
- the data lines are zero while the valid flag is low.

Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural reference array. These cover:
- whether the correct cell is the one written or read;
- isolation between addresses;
- read-after-write ordering;
- clearing on reset;
- the absence of writes while deselected.

The bench also shows the same behaviour in the 8 x 2 arrangement.

// File: rtl/coincident_ram_pkg.sv
package coincident_ram_pkg;

  // Strobes handed from control to the cell matrix each cycle
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } ram_strobe_t;

endpackage

// File: rtl/coincident_ram_dec.sv
module coincident_ram_dec #(
  parameter int IN_W = 2,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  selIn,
  output logic [OUT_N-1:0] selOut
);

  // One comparator per output line
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign selOut[i] = (selIn == IN_W'(i));
  end

endmodule

// File: rtl/coincident_ram_ctrl.sv
module coincident_ram_ctrl
  import coincident_ram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chipSel,
  input  logic              readWriteN,
  output ram_strobe_t       strobe,
  output logic [ROWS-1:0]   rowSel,
  output logic [COLS-1:0]   colSel
);

  logic [ROW_BITS-1:0] rowAddr;
  logic [COL_BITS-1:0] colAddr;

  assign rowAddr = addr[ADDR_W-1:COL_BITS];
  assign colAddr = addr[COL_BITS-1:0];

  coincident_ram_dec #(.IN_W(ROW_BITS)) u_rowDec (
    .selIn (rowAddr),
    .selOut(rowSel)
  );

  coincident_ram_dec #(.IN_W(COL_BITS)) u_colDec (
    .selIn (colAddr),
    .selOut(colSel)
  );

  always_comb begin
    strobe.wrEn = chipSel & ~readWriteN;
    strobe.rdEn = chipSel &  readWriteN;
  end

  // R2: each decoder has exactly one active line
  assert_row_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(rowSel) == 1);
  assert_col_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(colSel) == 1);

  // R4: a write and a read are never requested together
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(strobe.wrEn && strobe.rdEn));

endmodule

// File: rtl/coincident_ram_array.sv
module coincident_ram_array
  import coincident_ram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int DATA_W = 1,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS,
  localparam int WORDS = ROWS * COLS,
  localparam int FLAT_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ram_strobe_t       strobe,
  input  logic [ROWS-1:0]   rowSel,
  input  logic [COLS-1:0]   colSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  logic [FLAT_W-1:0] cellFlat;
  logic [WORDS-1:0]  wordSel;
  logic [DATA_W-1:0] rdWord;

  // Matrix of cells: one word per row/column crossing
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic [DATA_W-1:0] cellQ;

      assign wordSel[IDX] = rowSel[r] & colSel[c];

      always_ff @(posedge clk) begin
        if (rst) begin
          cellQ <= '0;
        end else if (strobe.wrEn && wordSel[IDX]) begin
          cellQ <= dataIn;
        end
      end

      assign cellFlat[IDX*DATA_W +: DATA_W] = cellQ;
    end
  end

  // Wired-OR of the selected word onto the shared read line
  always_comb begin
    rdWord = '0;
    for (int k = 0; k < WORDS; k++) begin
      rdWord = rdWord | (cellFlat[k*DATA_W +: DATA_W] & {DATA_W{wordSel[k]}});
    end
  end

  // Registered output with an enable flag modelling the disconnected state
  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else if (strobe.rdEn) begin
      dataOut   <= rdWord;
      dataValid <= 1'b1;
    end else begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end
  end

  // R3: without a write strobe, no cell in the matrix changes
  assert_hold_cells_R3: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrEn |=> $stable(cellFlat));

  // R6: data lines are quiet while the output is disabled
  assert_quiet_out_R6: assert property (@(posedge clk) disable iff (rst)
    !dataValid |-> dataOut == '0);

endmodule

// File: rtl/coincident_ram.sv
module coincident_ram
  import coincident_ram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int DATA_W = 1,
  localparam int ADDR_W = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              chipSel,
  input  logic              readWriteN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  ram_strobe_t     strobe;
  logic [ROWS-1:0] rowSel;
  logic [COLS-1:0] colSel;

  coincident_ram_ctrl #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .chipSel   (chipSel),
    .readWriteN(readWriteN),
    .strobe    (strobe),
    .rowSel    (rowSel),
    .colSel    (colSel)
  );

  coincident_ram_array #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS),
    .DATA_W  (DATA_W)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rowSel   (rowSel),
    .colSel   (colSel),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

  // R5: a read edge raises the valid flag on the next cycle
  assert_read_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (chipSel && readWriteN) |=> dataValid);

  // R6: a non-read edge leaves the output disabled
  assert_idle_invalid_R6: assert property (@(posedge clk) disable iff (rst)
    !(chipSel && readWriteN) |=> !dataValid);

endmodule

// File: tb/coincident_ram_tb.sv
module coincident_ram_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst;
  logic [3:0] addr;
  logic       dataIn;
  logic       chipSel;
  logic       readWriteN;
  logic       dataOut;
  logic       dataValid;

  logic [2:0] addr8;
  logic [1:0] dataIn8;
  logic [1:0] dataOut8;
  logic       dataValid8;

  coincident_ram u_dut (
    .clk(clk), .rst(rst), .addr(addr), .dataIn(dataIn),
    .chipSel(chipSel), .readWriteN(readWriteN),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  coincident_ram #(.ROW_BITS(2), .COL_BITS(1), .DATA_W(2)) u_dut8x2 (
    .clk(clk), .rst(rst), .addr(addr8), .dataIn(dataIn8),
    .chipSel(chipSel), .readWriteN(readWriteN),
    .dataOut(dataOut8), .dataValid(dataValid8)
  );

  logic       refA [16];
  logic [1:0] refB [8];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, check 2 ns after the rising edge
  task automatic doCycle(input logic r, input logic cs, input logic rw,
                         input logic [3:0] a, input logic [1:0] d, input string tag);
    logic       expV;
    logic       expD;
    logic [1:0] expD8;
    @(negedge clk);
    rst = r; chipSel = cs; readWriteN = rw;
    addr = a; dataIn = d[0]; addr8 = a[2:0]; dataIn8 = d;
    if (r) begin
      expV = 1'b0; expD = 1'b0; expD8 = 2'b00;
      for (int i = 0; i < 16; i++) refA[i] = 1'b0;
      for (int i = 0; i < 8; i++) refB[i] = 2'b00;
    end else begin
      expV  = cs & rw;
      expD  = expV ? refA[a] : 1'b0;
      expD8 = expV ? refB[a[2:0]] : 2'b00;
      if (cs && !rw) begin
        refA[a] = d[0];
        refB[a[2:0]] = d;
      end
    end
    @(posedge clk);
    #2;
    check({tag, " 16x1"}, {1'b0, dataValid, dataOut}, {1'b0, expV, expD});
    check({tag, " R9 8x2"}, {dataValid8, dataOut8}, {expV, expD8});
  endtask

  initial begin
    rst = 1'b1; chipSel = 1'b0; readWriteN = 1'b1;
    addr = '0; dataIn = 1'b0; addr8 = '0; dataIn8 = '0;
    for (int i = 0; i < 16; i++) refA[i] = 1'bx;
    for (int i = 0; i < 8; i++) refB[i] = 2'bxx;

    // R7: reset state, even with a read requested during reset
    doCycle(1, 1, 1, 4'd3, 2'd0, "R7 reset");
    doCycle(1, 1, 0, 4'd5, 2'd3, "R7 reset");
    for (int a = 0; a < 16; a++) doCycle(0, 1, 1, 4'(a), 2'd0, "R7 cleared");

    // R1, R4: distinct pattern at every address, then read back
    for (int a = 0; a < 16; a++) doCycle(0, 1, 0, 4'(a), 2'(a ^ (a >> 2)), "R4 write");
    for (int a = 0; a < 16; a++) doCycle(0, 1, 1, 4'(a), 2'd0, "R1 readback");

    // R6: deselected cycles with write level store nothing
    for (int a = 0; a < 16; a++) doCycle(0, 0, 0, 4'(a), ~2'(a ^ (a >> 2)), "R6 deselected");
    for (int a = 0; a < 16; a++) doCycle(0, 1, 1, 4'(a), 2'd0, "R6 unchanged");

    // R8: write then read the same address on the next cycle
    for (int a = 0; a < 16; a++) begin
      doCycle(0, 1, 0, 4'(a), 2'(3 - (a % 4)), "R8 write");
      doCycle(0, 1, 1, 4'(a), 2'd0, "R8 read after write");
    end

    // R3, R5: random interleaving, including deselected cycles
    for (int n = 0; n < 3000; n++) begin
      doCycle(0, ($urandom % 4) != 0, $urandom % 2, 4'($urandom), 2'($urandom), "R3 R5 random");
    end

    // R7: reset in mid-run, then a full sweep
    doCycle(1, 1, 0, 4'd9, 2'd3, "R7 mid reset");
    for (int a = 0; a < 16; a++) doCycle(0, 1, 1, 4'(a), 2'd0, "R7 cleared again");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all R) actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule